// File: doc/BRIEF.md
# Flash-Commit Transactional Line-State Array

This block holds the coherence state of N cache lines while a speculative transaction runs. Every line keeps a six-bit code: a transactional flag, an abort-on-invalidate flag, a two-bit MESI field, an outcome bit and a dirty-origin bit. Software-visible single-line operations read or write one line's state. Two whole-array operations, commit and abort, settle every line in a fixed two cycles without walking the lines.

The array settles all lines in two steps. First it drives an outcome value onto a broadcast line, and every line whose transactional flag is set latches that value into its outcome bit. Then it flash-clears the transactional and abort-on-invalidate flags everywhere. Lines that were transactionally modified then decode as M or I from the bits left behind, so their MESI field is never rewritten.

The array also decodes each code into one of twelve logical states. It flags the lines whose loss would doom the running transaction, and it proposes an eviction victim. Evicting a flagged line starts an abort by itself.

Top module: `tx_tag_array`

## Requirements
- R1: After reset every line holds code 6'b000000 and reads as logical state I. `busy_o`, `rd_valid_o`, `xabort_o` and `keep_o` are 0.
- R2: Operations are coded on `req_op_i` as follows: 0 none, 1 read, 2 write, 3 commit, 4 abort, 5 evict. Logical states are numbered I=0, S=1, E=2, M=3, TII=4, TSS=5, TEE=6, TMI=7, TMM=8, AS=9, AE=10, AM=11. Code bits, from bit 5 down, are transactional, abort-on-invalidate, MESI[1:0] (I=00, S=01, E=10, M=11), outcome, dirty-origin.
  - A write of logical state `req_state_i` to line `req_idx_i` stores these codes: I 000000, S 000100, E 001000, M 001111, TII 100000, TSS 100100, TEE 101000, TMI 101100, TMM 101101, AS 010100, AE 011000, AM 011101. Any state number from 12 to 15 stores the I code.
  - A read returns the line's code on `rd_code_o` and its decoded state on `rd_state_o`, with `rd_valid_o` high, in the cycle after the read is accepted.
- R3: An accepted commit raises `busy_o` for exactly the next cycle. Every transactional line then has its outcome bit set to 1. At the end of that cycle all transactional and abort-on-invalidate flags are 0. Results: TMI becomes 001110 (M), TMM becomes 001111 (M), TSS becomes 000110 (S), TEE becomes 001010 (E) and TII becomes 000010 (I).
- R4: An accepted abort behaves like a commit, but it writes 0 into the outcome bit. Results: TMI becomes 001100, which decodes as I. TMM becomes 001101 (M), TSS becomes 000100 (S) and TII becomes 000000 (I).
- R5: Decoding rules:
  - A line with both flags clear and MESI bits 11 decodes as M only if its outcome bit or its dirty-origin bit is set, and as I otherwise.
  - A transactional line with MESI bits 11 decodes as TMM if its dirty-origin bit is set, and as TMI otherwise.
  - A line with only the abort-on-invalidate flag set decodes as AS, AE or AM by its MESI bits, and as I when they are 00.
- R6: Commit and abort leave the outcome bit of non-transactional lines unchanged. M stays 001111 and AM becomes 001101 (M).
- R7: No request is accepted while `busy_o` is high. A write in that cycle changes no line, and a read in that cycle produces no `rd_valid_o`.
- R8: `keep_o[i]` is 1 exactly when line i decodes as TMI or has its abort-on-invalidate flag set.
- R9: `victim_idx_o` is the lowest line that decodes as I. If no line decodes as I, it is the lowest line with `keep_o` clear. If every line has `keep_o` set, `victim_idx_o` is 0 and `victim_forced_o` is 1; otherwise `victim_forced_o` is 0.
- R10: An accepted evict clears the indexed line to 000000. If that line had `keep_o` set, `xabort_o` pulses in the next cycle and the array runs the R4 abort, with `busy_o` high in that cycle. Otherwise `xabort_o` and `busy_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | Operation code |
| req_idx_i | input | IDX_W | Line index for read, write, evict |
| req_state_i | input | 4 | Logical state to write |
| busy_o | output | 1 | Commit/abort flash phase; requests ignored |
| rd_valid_o | output | 1 | Read result valid |
| rd_state_o | output | 4 | Decoded logical state of the read line |
| rd_code_o | output | 6 | Raw code of the read line |
| keep_o | output | N | Per-line must-keep hint |
| victim_idx_o | output | IDX_W | Suggested eviction victim |
| victim_forced_o | output | 1 | Every line is must-keep |
| xabort_o | output | 1 | Eviction-triggered abort pulse |

## Verification
Timing of each result, counted from the clock edge that accepts a request:
- Read results appear in the cycle after that edge.
- A write's effect is visible to a read accepted at the next edge.
- `busy_o` and `xabort_o` are high in the single cycle after the edge that accepts a commit, abort or flagged eviction.
- `keep_o` and the victim outputs follow the stored codes with no added delay.

The bench drives every input on the falling edge. A driver task queues each read's expected state and code before the accepting edge. A monitor compares `rd_valid_o` results against that queue on the following falling edge, and reports any unexpected result as a failure. Busy, abort-pulse, keep and victim outputs are checked on the falling edge at the exact cycle given above.

// File: rtl/tx_tag_pkg.sv
package tx_tag_pkg;

  typedef struct packed {
    logic       t;    // transactional
    logic       a;    // abort-on-invalidate
    logic [1:0] coh;  // I=00 S=01 E=10 M=11
    logic       oc;   // outcome (commit=1 / abort=0)
    logic       dk;   // dirty-origin: was TMM (1) or TMI (0)
  } line_code_t;

  localparam int CODE_W = $bits(line_code_t);

  typedef enum logic [3:0] {
    LS_I, LS_S, LS_E, LS_M, LS_TII, LS_TSS, LS_TEE, LS_TMI, LS_TMM,
    LS_AS, LS_AE, LS_AM
  } lstate_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_COMMIT, OP_ABORT, OP_EVICT
  } op_e;

  function automatic line_code_t encode_state(input logic [3:0] s);
    line_code_t c;
    c = '0;
    case (s)
      4'd1:  c.coh = 2'b01;
      4'd2:  c.coh = 2'b10;
      4'd3:  begin c.coh = 2'b11; c.oc = 1'b1; c.dk = 1'b1; end
      4'd4:  c.t = 1'b1;
      4'd5:  begin c.t = 1'b1; c.coh = 2'b01; end
      4'd6:  begin c.t = 1'b1; c.coh = 2'b10; end
      4'd7:  begin c.t = 1'b1; c.coh = 2'b11; end
      4'd8:  begin c.t = 1'b1; c.coh = 2'b11; c.dk = 1'b1; end
      4'd9:  begin c.a = 1'b1; c.coh = 2'b01; end
      4'd10: begin c.a = 1'b1; c.coh = 2'b10; end
      4'd11: begin c.a = 1'b1; c.coh = 2'b11; c.dk = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic lstate_e decode_code(input line_code_t c);
    lstate_e s;
    if (c.t) begin
      case (c.coh)
        2'b00:   s = LS_TII;
        2'b01:   s = LS_TSS;
        2'b10:   s = LS_TEE;
        default: s = c.dk ? LS_TMM : LS_TMI;
      endcase
    end else if (c.a) begin
      case (c.coh)
        2'b00:   s = LS_I;
        2'b01:   s = LS_AS;
        2'b10:   s = LS_AE;
        default: s = LS_AM;
      endcase
    end else begin
      case (c.coh)
        2'b00:   s = LS_I;
        2'b01:   s = LS_S;
        2'b10:   s = LS_E;
        default: s = (c.oc | c.dk) ? LS_M : LS_I;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/tx_tag_cell.sv
module tx_tag_cell
  import tx_tag_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  line_code_t wr_code_i,
  input  logic       bcast_en_i,
  input  logic       bcast_val_i,
  input  logic       flash_en_i,
  output line_code_t code_o,
  output logic       inv_o,
  output logic       keep_o
);
  line_code_t code_q;
  lstate_e    dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (wr_en_i) begin
      code_q <= wr_code_i;
    end else begin
      if (bcast_en_i && code_q.t) code_q.oc <= bcast_val_i;
      if (flash_en_i) begin
        code_q.t <= 1'b0;
        code_q.a <= 1'b0;
      end
    end
  end

  assign dec    = decode_code(code_q);
  assign code_o = code_q;
  assign inv_o  = (dec == LS_I);
  assign keep_o = (dec == LS_TMI) | code_q.a;
endmodule

// File: rtl/tx_tag_ctrl.sv
module tx_tag_ctrl
  import tx_tag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  op_e  op_i,
  input  logic sel_keep_i,
  output logic acc_o,
  output logic bcast_en_o,
  output logic bcast_val_o,
  output logic flash_en_o,
  output logic busy_o,
  output logic xabort_o
);
  logic flash_q, xabort_q;
  logic start_commit, start_abort, evict_doom;

  assign acc_o        = req_valid_i & ~flash_q;
  assign evict_doom   = acc_o & (op_i == OP_EVICT) & sel_keep_i;
  assign start_commit = acc_o & (op_i == OP_COMMIT);
  assign start_abort  = (acc_o & (op_i == OP_ABORT)) | evict_doom;

  assign bcast_en_o  = start_commit | start_abort;
  assign bcast_val_o = start_commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flash_q  <= 1'b0;
      xabort_q <= 1'b0;
    end else begin
      flash_q  <= bcast_en_o;
      xabort_q <= evict_doom;
    end
  end

  assign flash_en_o = flash_q;
  assign busy_o     = flash_q;
  assign xabort_o   = xabort_q;
endmodule

// File: rtl/tx_tag_victim.sv
module tx_tag_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     inv_i,
  input  logic [N-1:0]     keep_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             forced_o
);
  logic [IDX_W-1:0] first_inv, first_free;
  logic             any_inv, any_free;

  always_comb begin
    first_inv  = '0;
    first_free = '0;
    any_inv    = 1'b0;
    any_free   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (inv_i[i]) begin
        first_inv = IDX_W'(i);
        any_inv   = 1'b1;
      end
      if (!keep_i[i]) begin
        first_free = IDX_W'(i);
        any_free   = 1'b1;
      end
    end
  end

  assign idx_o    = any_inv ? first_inv : (any_free ? first_free : '0);
  assign forced_o = ~any_inv & ~any_free;
endmodule

// File: rtl/tx_tag_array.sv
module tx_tag_array
  import tx_tag_pkg::*;
#(
  parameter  int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_op_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [3:0]       req_state_i,
  output logic             busy_o,
  output logic             rd_valid_o,
  output logic [3:0]       rd_state_o,
  output logic [5:0]       rd_code_o,
  output logic [N-1:0]     keep_o,
  output logic [IDX_W-1:0] victim_idx_o,
  output logic             victim_forced_o,
  output logic             xabort_o
);
  op_e        op;
  logic       acc, bcast_en, bcast_val, flash_en;
  logic       sel_keep;
  line_code_t wr_code, sel_code, rd_code_q;
  logic       rd_valid_q;
  line_code_t codes [N];
  logic [N-1:0] inv_v, keep_v, sel_v;

  assign op      = op_e'(req_op_i);
  assign wr_code = (op == OP_EVICT) ? '0 : encode_state(req_state_i);

  tx_tag_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .op_i        (op),
    .sel_keep_i  (sel_keep),
    .acc_o       (acc),
    .bcast_en_o  (bcast_en),
    .bcast_val_o (bcast_val),
    .flash_en_o  (flash_en),
    .busy_o      (busy_o),
    .xabort_o    (xabort_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_line
    assign sel_v[g] = (req_idx_i == IDX_W'(g));
    tx_tag_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (acc & sel_v[g] & ((op == OP_WRITE) | (op == OP_EVICT))),
      .wr_code_i   (wr_code),
      .bcast_en_i  (bcast_en),
      .bcast_val_i (bcast_val),
      .flash_en_i  (flash_en),
      .code_o      (codes[g]),
      .inv_o       (inv_v[g]),
      .keep_o      (keep_v[g])
    );
  end

  always_comb begin
    sel_code = '0;
    sel_keep = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_v[i]) begin
        sel_code = codes[i];
        sel_keep = keep_v[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_code_q  <= '0;
    end else begin
      rd_valid_q <= acc & (op == OP_READ);
      if (acc && op == OP_READ) rd_code_q <= sel_code;
    end
  end

  tx_tag_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .inv_i    (inv_v),
    .keep_i   (keep_v),
    .idx_o    (victim_idx_o),
    .forced_o (victim_forced_o)
  );

  assign rd_valid_o = rd_valid_q;
  assign rd_code_o  = rd_code_q;
  assign rd_state_o = decode_code(rd_code_q);
  assign keep_o     = keep_v;
endmodule

// File: rtl/tx_tag_array_chk.sv
module tx_tag_array_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [2:0]       req_op_i,
  input logic             busy_o,
  input logic             rd_valid_o,
  input logic [N-1:0]     keep_o,
  input logic [IDX_W-1:0] victim_idx_o,
  input logic             victim_forced_o,
  input logic             xabort_o
);
  // R2: accepted read yields a result next cycle
  p_read_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd1 && !busy_o) |=> rd_valid_o);

  // R7: nothing accepted while busy yields a read result
  p_busy_no_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o);

  // R3: commit raises busy for one cycle only
  p_commit_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd3 && !busy_o) |=> busy_o);

  p_busy_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  // R4: after flash clear no line is must-keep
  p_flash_clears_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (keep_o == '0));

  // R9: an unforced victim is never a must-keep line
  p_victim_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !victim_forced_o |-> !keep_o[victim_idx_o]);

  // R10: eviction abort pulse coincides with the flash phase
  p_xabort_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xabort_o |-> busy_o);
endmodule

bind tx_tag_array tx_tag_array_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_op_i        (req_op_i),
  .busy_o          (busy_o),
  .rd_valid_o      (rd_valid_o),
  .keep_o          (keep_o),
  .victim_idx_o    (victim_idx_o),
  .victim_forced_o (victim_forced_o),
  .xabort_o        (xabort_o)
);

// File: tb/tx_tag_array_bench.sv
module tx_tag_array_bench;
  localparam int N     = 8;
  localparam int IDX_W = 3;

  localparam logic [2:0] OP_RD = 3'd1, OP_WR = 3'd2, OP_CM = 3'd3,
                         OP_AB = 3'd4, OP_EV = 3'd5;
  localparam logic [3:0] S_I = 4'd0, S_S = 4'd1, S_E = 4'd2, S_M = 4'd3,
                         S_TII = 4'd4, S_TSS = 4'd5, S_TEE = 4'd6,
                         S_TMI = 4'd7, S_TMM = 4'd8, S_AS = 4'd9,
                         S_AM = 4'd11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [2:0]       req_op = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [3:0]       req_state = '0;
  logic             busy, rd_valid, victim_forced, xabort;
  logic [3:0]       rd_state;
  logic [5:0]       rd_code;
  logic [N-1:0]     keep;
  logic [IDX_W-1:0] victim_idx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] st;
    logic [5:0] code;
    string      req;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  tx_tag_array #(.N(N)) u_tx_tag_array (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .req_valid_i     (req_valid),
    .req_op_i        (req_op),
    .req_idx_i       (req_idx),
    .req_state_i     (req_state),
    .busy_o          (busy),
    .rd_valid_o      (rd_valid),
    .rd_state_o      (rd_state),
    .rd_code_o       (rd_code),
    .keep_o          (keep),
    .victim_idx_o    (victim_idx),
    .victim_forced_o (victim_forced),
    .xabort_o        (xabort)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare read results against scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R7 unexpected read result actual=%0h expected=none", rd_code);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check({e.req, " state"}, 32'(rd_state), 32'(e.st));
        check({e.req, " code"}, 32'(rd_code), 32'(e.code));
      end
    end
  end

  task automatic issue(input logic [2:0] op, input int idx, input logic [3:0] st);
    req_valid = 1'b1;
    req_op    = op;
    req_idx   = IDX_W'(idx);
    req_state = st;
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = '0;
  endtask

  task automatic rd(input int idx, input logic [3:0] st, input logic [5:0] code, input string req);
    exp_t e;
    e.st = st; e.code = code; e.req = req;
    expq.push_back(e);
    issue(OP_RD, idx, 4'd0);
  endtask

  task automatic wr(input int idx, input logic [3:0] st);
    issue(OP_WR, idx, st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 keep", 32'(keep), 0);
    check("R1 xabort", 32'(xabort), 0);
    check("R1 rd_valid", 32'(rd_valid), 0);
    for (int i = 0; i < N; i++) rd(i, S_I, 6'b000000, "R1 reset line");

    // R2 writes and readback
    wr(0, S_TMI); wr(1, S_TMM); wr(2, S_TSS); wr(3, S_M);
    wr(4, S_AM);  wr(5, S_AS);  wr(6, S_TEE); wr(7, S_E);
    rd(0, S_TMI, 6'b101100, "R2 TMI"); rd(1, S_TMM, 6'b101101, "R2 TMM");
    rd(2, S_TSS, 6'b100100, "R2 TSS"); rd(3, S_M,   6'b001111, "R2 M");
    rd(4, S_AM,  6'b011101, "R2 AM");  rd(5, S_AS,  6'b010100, "R2 AS");
    rd(6, S_TEE, 6'b101000, "R2 TEE"); rd(7, S_E,   6'b001000, "R2 E");
    // R8 keep hints, R9 victim without invalid lines
    check("R8 keep", 32'(keep), 32'h31);
    check("R9 victim non-keep", 32'(victim_idx), 1);
    check("R9 not forced", 32'(victim_forced), 0);

    // R3 commit; R7 write during busy ignored
    issue(OP_CM, 0, 4'd0);
    check("R3 busy after commit", 32'(busy), 1);
    check("R3 no xabort", 32'(xabort), 0);
    wr(3, S_I);
    check("R3 busy one cycle", 32'(busy), 0);
    check("R3 keep cleared", 32'(keep), 0);
    rd(0, S_M, 6'b001110, "R3 TMI commit");
    rd(1, S_M, 6'b001111, "R3 TMM commit");
    rd(2, S_S, 6'b000110, "R3 TSS commit");
    rd(3, S_M, 6'b001111, "R7 write ignored / R6 M kept");
    rd(4, S_M, 6'b001101, "R6 AM after commit");
    rd(5, S_S, 6'b000100, "R6 AS after commit");
    rd(6, S_E, 6'b001010, "R3 TEE commit");
    rd(7, S_E, 6'b001000, "R6 E kept");

    // R4 abort and R5 decode of leftover codes
    wr(0, S_TMI); wr(1, S_TMM); wr(2, S_TSS); wr(3, S_TII);
    issue(OP_AB, 0, 4'd0);
    check("R4 busy after abort", 32'(busy), 1);
    issue(OP_RD, 0, 4'd0); // R7: read during busy gives no result
    check("R4 busy done", 32'(busy), 0);
    rd(0, S_I, 6'b001100, "R5 TMI abort decodes I");
    rd(1, S_M, 6'b001101, "R4 TMM abort");
    rd(2, S_S, 6'b000100, "R4 TSS abort");
    rd(3, S_I, 6'b000000, "R4 TII abort");
    check("R9 victim invalid line", 32'(victim_idx), 0);

    // R9 forced victim
    for (int i = 0; i < N; i++) wr(i, S_TMI);
    check("R8 all keep", 32'(keep), 32'hFF);
    check("R9 forced", 32'(victim_forced), 1);
    check("R9 forced idx", 32'(victim_idx), 0);

    // R10 evict a must-keep line
    issue(OP_EV, 5, 4'd0);
    check("R10 xabort pulse", 32'(xabort), 1);
    check("R10 busy", 32'(busy), 1);
    @(negedge clk);
    check("R10 xabort single", 32'(xabort), 0);
    rd(5, S_I, 6'b000000, "R10 evicted line");
    rd(6, S_I, 6'b001100, "R10 abort hit TMI");
    check("R9 victim after abort", 32'(victim_idx), 0);

    // R10 evict of a free line starts no abort
    wr(2, S_S); wr(0, S_E); wr(1, S_TMM);
    issue(OP_EV, 2, 4'd0);
    check("R10 no xabort", 32'(xabort), 0);
    check("R10 no busy", 32'(busy), 0);
    rd(2, S_I, 6'b000000, "R10 free evict");
    rd(1, S_TMM, 6'b101101, "R10 no abort side effect");
    @(negedge clk);
    check("R2 scoreboard drained", 32'(expq.size()), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule